// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor

This block adds or subtracts two 64-bit operands with a carry chain that can be cut at byte boundaries. A 2-bit lane-size mode picks how the word is split. It can be one 64-bit value, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. All lanes of one word use the same operation and are computed in the same pass. One byte-sliced adder therefore serves all four packed formats. Eight separate adders are not needed.

Each lane wraps modulo its own width. The block does not saturate. A per-byte carry vector reports the carry out of each active lane at the position of that lane's top byte. A parameter chooses between a purely combinational path and a single output register stage.

Top module: `simd_lane_adder`

## Requirements
- R1: With mode 2'b00 the block forms one 64-bit sum or difference, wrapping modulo 2^64.
- R2: With mode 2'b01 the word is two independent 32-bit lanes: bits 31:0 and bits 63:32.
- R3: With mode 2'b10 the word is four independent 16-bit lanes, each aligned to a multiple of 16 bits.
- R4: With mode 2'b11 the word is eight independent 8-bit lanes, one per byte.
- R5: With sub = 1, every lane gives op_a minus op_b modulo the lane width. The hardware inverts op_b and feeds a carry-in of 1 into the lowest byte of each lane.
- R6: Bit k of carry_out is the carry out of the lane whose most significant byte is byte k, meaning bits 8k+7 to 8k. All other bits of carry_out read 0. In subtraction a 1 on this flag means no borrow.
- R7: A carry never crosses a lane boundary. A lane that overflows leaves the result of the lane above it unchanged.
- R8: With OUT_REG = 0, result and carry_out follow the inputs with no clock. With OUT_REG = 1 they appear one clock later, and an active-low reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | 64 | First operand, packed lanes |
| op_b | input | 64 | Second operand, packed lanes |
| mode | input | 2 | Lane size: 00 = 64, 01 = 32, 10 = 16, 11 = 8 bits |
| sub | input | 1 | 0 = add, 1 = subtract (op_a - op_b) |
| result | output | 64 | Packed per-lane sum or difference |
| carry_out | output | 8 | Per-lane carry-out flag at the lane's top byte position |

## Verification
A lane can overflow in the same cycle that the next lane computes its own sum, so the carry cut and the neighbour's arithmetic fall together. The bench sets this up with operands whose lanes are all-ones plus a low one in every byte. A carry is then generated at every byte boundary at once, and this is repeated under each of the four modes. Each lane's result and the carry_out vector are compared with hand-worked values. Random operands are also compared with a lane-by-lane reference model.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
   typedef enum logic [1:0] {
      LANE_FULL = 2'b00,
      LANE_HALF = 2'b01,
      LANE_QUAD = 2'b10,
      LANE_BYTE = 2'b11
   } lane_mode_e;

   // bytes in one lane for a given mode on an nbytes-wide datapath
   function automatic int bytes_per_lane(input int nbytes, input logic [1:0] m);
      return nbytes >> m;
   endfunction

   // true when byte idx holds the most significant byte of its lane
   function automatic logic is_lane_top(input int idx, input int nbytes, input logic [1:0] m);
      return ((idx + 1) % bytes_per_lane(nbytes, m)) == 0;
   endfunction
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
   parameter int NUM_BYTES = 8
) (
   input  logic [1:0]           mode,
   output logic [NUM_BYTES-1:0] lane_start,
   output logic [NUM_BYTES-1:0] lane_top
);
   always_comb begin
      int span_mask;
      span_mask = (NUM_BYTES >> mode) - 1;
      for (int i = 0; i < NUM_BYTES; i++) begin
         lane_start[i] = (i & span_mask) == 0;
         lane_top[i]   = (i & span_mask) == span_mask;
      end
   end
endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         invert_b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] b_eff;

   assign b_eff = invert_b ? ~b : b;
   assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
   parameter int SLICE_W   = 8,
   parameter int NUM_BYTES = 8,
   parameter bit OUT_REG   = 1'b0,
   localparam int DW       = SLICE_W * NUM_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DW-1:0]        op_a,
   input  logic [DW-1:0]        op_b,
   input  logic [1:0]           mode,
   input  logic                 sub,
   output logic [DW-1:0]        result,
   output logic [NUM_BYTES-1:0] carry_out
);
   import simd_add_pkg::*;

   if (NUM_BYTES < 8 || (NUM_BYTES & (NUM_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("NUM_BYTES must be a power of two and at least 8");
   end
   if (SLICE_W < 1) begin : g_bad_slice
      $error("SLICE_W must be positive");
   end

   logic [NUM_BYTES-1:0] lane_start, lane_top;
   logic [NUM_BYTES-1:0] slice_cin, slice_cout;
   logic [DW-1:0]        sum_c;
   logic [NUM_BYTES-1:0] flag_c;

   simd_lane_map #(.NUM_BYTES(NUM_BYTES)) u_map (
      .mode       (mode),
      .lane_start (lane_start),
      .lane_top   (lane_top)
   );

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
      if (g == 0) begin : g_first
         assign slice_cin[g] = sub;
      end else begin : g_chain
         // cut the chain where a new lane begins
         assign slice_cin[g] = lane_start[g] ? sub : slice_cout[g-1];
      end

      simd_byte_slice #(.W(SLICE_W)) u_slice (
         .a        (op_a[g*SLICE_W +: SLICE_W]),
         .b        (op_b[g*SLICE_W +: SLICE_W]),
         .invert_b (sub),
         .cin      (slice_cin[g]),
         .sum      (sum_c[g*SLICE_W +: SLICE_W]),
         .cout     (slice_cout[g])
      );

      assign flag_c[g] = lane_top[g] & slice_cout[g];

      // R4: in byte mode each slice is a standalone adder
      assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == LANE_BYTE && !sub) |->
         ({flag_c[g], sum_c[g*SLICE_W +: SLICE_W]} ==
          {1'b0, op_a[g*SLICE_W +: SLICE_W]} + {1'b0, op_b[g*SLICE_W +: SLICE_W]}));
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            result    <= '0;
            carry_out <= '0;
         end else begin
            result    <= sum_c;
            carry_out <= flag_c;
         end
      end

      assert_reg_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (result == $past(sum_c) && carry_out == $past(flag_c)));
   end else begin : g_comb
      assign result    = sum_c;
      assign carry_out = flag_c;
   end

   // independent lane-top mask for checking flag placement
   logic [NUM_BYTES-1:0] top_ref;
   always_comb begin
      for (int i = 0; i < NUM_BYTES; i++) top_ref[i] = is_lane_top(i, NUM_BYTES, mode);
   end

   assert_full_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LANE_FULL && !sub) |->
      ({flag_c[NUM_BYTES-1], sum_c} == {1'b0, op_a} + {1'b0, op_b}));

   assert_full_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LANE_FULL && sub) |-> (sum_c == op_a - op_b));

   assert_flag_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_c & ~top_ref) == '0);
endmodule

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [1:0]  mode = 2'b00;
   logic        sub = 1'b0;
   logic [63:0] result;
   logic [7:0]  carry_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   simd_lane_adder #(.SLICE_W(8), .NUM_BYTES(8), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .mode(mode), .sub(sub), .result(result), .carry_out(carry_out)
   );

   localparam int NV = 8;
   localparam logic [63:0] TA [NV] = '{
      64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0001, 64'h8000_7FFF_8000_7FFF,
      64'h7F80_FF01_00FE_807F, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_0000_FFFF_0001};
   localparam logic [63:0] TB [NV] = '{
      64'hFEDC_BA98_7654_3210, 64'h0000_0001_FFFF_FFFF, 64'h8000_0001_8000_0001,
      64'h8180_01FF_0102_7F81, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0000_0000_0000_0001, 64'h1234_0001_0001_0002};
   localparam logic [1:0] TM [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd3, 2'd0, 2'd2};
   localparam logic       TS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   // per-lane reference built from the requirements
   task automatic ref_model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                            input logic s, output logic [63:0] r, output logic [7:0] c);
      int w;
      logic [64:0] mask, la, lb, t;
      w = 64 >> m;
      mask = (65'd1 << w) - 65'd1;
      r = '0;
      c = '0;
      for (int l = 0; l < 64 / w; l++) begin
         la = ({1'b0, a} >> (l * w)) & mask;
         lb = ({1'b0, b} >> (l * w)) & mask;
         t = s ? (la + (~lb & mask) + 65'd1) : (la + lb);
         r = r | (64'(t & mask) << (l * w));
         c[((l + 1) * w) / 8 - 1] = t[w];
      end
   endtask

   task automatic check(input string req, input logic [63:0] exp_r, input logic [7:0] exp_c);
      checks++;
      if (result !== exp_r || carry_out !== exp_c) begin
         errors++;
         $display("FAIL %s: result=%h carry=%h expected result=%h carry=%h",
                  req, result, carry_out, exp_r, exp_c);
      end
   endtask

   // drive at a falling edge, let the register capture, sample at the next falling edge
   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                        input logic s);
      op_a = a; op_b = b; mode = m; sub = s;
      @(negedge clk);
   endtask

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   initial begin
      logic [63:0] er;
      logic [7:0]  ec;
      // reset: register holds zero even with live inputs (R8)
      op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; mode = 2'd0;
      repeat (3) @(negedge clk);
      check("R8 reset", 64'h0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      // the register now holds the sum computed during that clock (R8 latency)
      check("R8 latency", 64'h0, 8'h80);

      // table walk
      for (int v = 0; v < NV; v++) begin
         apply(TA[v], TB[v], TM[v], TS[v]);
         ref_model(TA[v], TB[v], TM[v], TS[v], er, ec);
         check(TS[v] ? "R5 table" : mode_req(TM[v]), er, ec);
      end

      // carries generated at every byte boundary in the same cycle (R7, R6)
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd3, 1'b0);
      check("R7 R4 byte cut", 64'h0000_0000_0000_0000, 8'hFF);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd2, 1'b0);
      check("R7 R3 16-bit cut", 64'h0100_0100_0100_0100, 8'hAA);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd1, 1'b0);
      check("R7 R2 32-bit cut", 64'h0101_0100_0101_0100, 8'h88);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 1'b0);
      check("R1 R6 full chain", 64'h0101_0101_0101_0100, 8'h80);
      // one lane overflows, neighbour unchanged (R7)
      apply(64'h0000_0005_FFFF_FFFF, 64'h0000_0003_0000_0001, 2'd1, 1'b0);
      check("R7 lane isolation", 64'h0000_0008_0000_0000, 8'h08);
      // subtraction borrow and no-borrow flags (R5, R6)
      apply(64'h0, 64'h0101_0101_0101_0101, 2'd3, 1'b1);
      check("R5 R6 borrow", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
      apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'd2, 1'b1);
      check("R5 R6 equal", 64'h0, 8'hAA);

      // random sweep per mode and operation
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 20; k++) begin
               logic [63:0] ra, rb;
               ra = {$urandom, $urandom};
               rb = {$urandom, $urandom};
               apply(ra, rb, 2'(m), 1'(s));
               ref_model(ra, rb, 2'(m), 1'(s), er, ec);
               check(s != 0 ? "R5 random" : mode_req(2'(m)), er, ec);
            end
         end
      end

      // reset again clears the register (R8)
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 re-reset", 64'h0, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule